// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block divides the system clock down to a 32.768 kHz time base and, from a free-running counter on that time base, produces a periodic event. A 4-bit rate field selects the event period. Two enables control the outputs. With the interrupt enable set, each event raises a one-clock pulse that sets the periodic flag and a matching pulse that sets the summary interrupt flag. With the square-wave enable set, the square-wave output toggles on every event.

Events are not timed from the moment a rate is written. They fall on the multiples of the period on the free-running counter. Changing the rate therefore moves the next event to the next aligned boundary of the new period. The flag register and the interrupt controller that take these pulses sit outside the block.

Top module: `periodic_irq_gen`

## Requirements
- R1: A rate field of 0 stops the generator: no flag pulse and no square-wave toggle occur while it is 0.
- R2: Rate codes 1 and 2 give the same periods as codes 8 and 9: 128 and 256 time-base ticks.
- R3: For rate codes 3 to 15, the period is 2^(code-1) time-base ticks. Code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R4: The generator runs only while the interrupt enable or the square-wave enable is 1. With both at 0 there are no flag pulses and the square wave stays low.
- R5: An event happens on the time-base tick at which the free-running 15-bit tick counter, after it increments, is a multiple of the period. Reset sets the counter to 0, and a rate write never resets it.
- R6: On an event with the interrupt enable set, `pf_set` and `irq_set` are both high for exactly one clock. Otherwise both are low.
- R7: While the square-wave enable is 1, `sqw_out` toggles on each event. When the enable is 0, `sqw_out` is driven low from the next clock.
- R8: A new rate code takes effect from the next tick. The first event after the change falls on an aligned boundary of the new period, and no extra pulse occurs.
- R9: The prescaler issues one time-base tick every `CLK_DIV` clocks. The first tick comes `CLK_DIV` clocks after reset is released.
- R10: During and right after reset, `pf_set`, `irq_set` and `sqw_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 4 | Rate code; 0 stops the generator |
| pie_en | input | 1 | Enables the periodic flag pulses |
| sqw_en | input | 1 | Enables the square-wave output |
| pf_set | output | 1 | One-clock pulse that sets the periodic flag |
| irq_set | output | 1 | One-clock pulse that sets the summary interrupt flag |
| sqw_out | output | 1 | Square wave that toggles on each event |

## Verification
The assertions assume `CLK_DIV` is at least 2. The rate and enable inputs must change only between clock edges and be held stable around each edge. The single-cycle pulse property relies on no two time-base ticks being adjacent. The bench uses a divider of 4 and drives every input change on the falling edge. It steps through rate changes in the middle of a period, both aliased codes, code 0, and each combination of the enables. All of these stay inside the input assumptions above.

// File: rtl/pit_pkg.sv
// Package: shared sizes and the rate-code decode for the periodic generator.
// Assumes the time base is 32768 ticks per second (15-bit counter).
package pit_pkg;
    localparam int TB_W   = 15;
    localparam int RATE_W = 4;

    // Map a rate code to the low-bit mask of its period (period - 1).
    function automatic logic [TB_W-1:0] period_mask(input logic [RATE_W-1:0] code);
        logic [RATE_W-1:0] eff;
        logic [TB_W:0]     per;
        eff = code;
        if (code == RATE_W'(1))      eff = RATE_W'(8);
        else if (code == RATE_W'(2)) eff = RATE_W'(9);
        if (eff == '0) return '0;
        per = (TB_W+1)'(1) << (eff - RATE_W'(1));
        return per[TB_W-1:0] - 1'b1;
    endfunction
endpackage

// File: rtl/pit_prescaler.sv
// Prescaler: divides clk by CLK_DIV into a one-clock time-base tick.
// Assumes CLK_DIV >= 2, so ticks are never on adjacent clocks.
module pit_prescaler #(
    parameter int CLK_DIV = 7629
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);

    logic [DW-1:0] div_cnt;

    // Count clocks and emit a registered tick on every wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else if (div_cnt == LAST) begin
            div_cnt <= '0;
            tick    <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            tick    <= 1'b0;
        end
    end
endmodule

// File: rtl/pit_timebase.sv
// Timebase: a free-running tick counter that only reset clears.
// Assumes the period masks used with it divide 2^TB_W.
module pit_timebase
    import pit_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [TB_W-1:0] cnt
);
    // Advance once per tick and wrap naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pit_event.sv
// Event stage: detects aligned period boundaries and drives the flag pulses
// and the square wave. Assumes tick is a one-clock pulse and that cnt is the
// count before this tick's increment.
module pit_event
    import pit_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [TB_W-1:0] cnt,
    input  logic [TB_W-1:0] mask,
    input  logic            active,
    input  logic            pie_en,
    input  logic            sqw_en,
    output logic            pf_set,
    output logic            irq_set,
    output logic            sqw_out
);
    logic [TB_W-1:0] cnt_nxt;
    logic            boundary;

    // Decide whether the count this tick reaches is a multiple of the period.
    always_comb begin
        cnt_nxt  = cnt + 1'b1;
        boundary = tick && active && ((cnt_nxt & mask) == '0);
    end

    // Register the periodic flag pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pf_set <= 1'b0;
        else        pf_set <= boundary && pie_en;
    end

    // Register the summary interrupt pulse that goes with the periodic flag.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_set <= 1'b0;
        else        irq_set <= boundary && pie_en;
    end

    // Toggle the square wave on boundaries; hold it low when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !sqw_en) sqw_out <= 1'b0;
        else if (boundary)     sqw_out <= !sqw_out;
    end
endmodule

// File: rtl/periodic_irq_gen.sv
// Top: periodic interrupt and square-wave generator on a 32 kHz time base.
// Assumes rate_sel and the enables are synchronous to clk.
module periodic_irq_gen
    import pit_pkg::*;
#(
    parameter int CLK_DIV = 7629
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              pie_en,
    input  logic              sqw_en,
    output logic              pf_set,
    output logic              irq_set,
    output logic              sqw_out
);
    logic            tick;
    logic [TB_W-1:0] cnt;
    logic [TB_W-1:0] mask;
    logic            active;

    // Decode the rate field and the run condition.
    always_comb begin
        mask   = period_mask(rate_sel);
        active = (rate_sel != '0) && (pie_en || sqw_en);
    end

    pit_prescaler #(.CLK_DIV(CLK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    pit_timebase u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt)
    );

    pit_event u_evt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .mask(mask),
        .active(active), .pie_en(pie_en), .sqw_en(sqw_en),
        .pf_set(pf_set), .irq_set(irq_set), .sqw_out(sqw_out)
    );
endmodule

// File: rtl/periodic_irq_gen_chk.sv
// Checker: port-level properties of the periodic generator, bound to the top.
// Assumes CLK_DIV >= 2 and inputs that are stable around each clock edge.
module periodic_irq_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] rate_sel,
    input logic       pie_en,
    input logic       sqw_en,
    input logic       pf_set,
    input logic       irq_set,
    input logic       sqw_out
);
    assert_rate_zero_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rate_sel) == 4'd0) |-> (!pf_set && !irq_set));

    assert_idle_when_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!pie_en && !sqw_en)) |-> (!pf_set && !sqw_out));

    assert_flags_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_set == irq_set);

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_set |=> !pf_set);

    assert_pf_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_set |-> $past(pie_en));

    assert_sqw_low_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sqw_en) |-> !sqw_out);

    assert_sqw_rise_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sqw_out) |-> $past(sqw_en));
endmodule

bind periodic_irq_gen periodic_irq_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .pie_en(pie_en),
    .sqw_en(sqw_en), .pf_set(pf_set), .irq_set(irq_set), .sqw_out(sqw_out)
);

// File: tb/periodic_irq_gen_tb.sv
module periodic_irq_gen_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       pie_en = 1'b0;
    logic       sqw_en = 1'b0;
    logic       pf_set, irq_set, sqw_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    periodic_irq_gen #(.CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .pie_en(pie_en),
        .sqw_en(sqw_en), .pf_set(pf_set), .irq_set(irq_set), .sqw_out(sqw_out)
    );

    function automatic int period_of(input int code);
        int eff;
        eff = (code == 1) ? 8 : (code == 2) ? 9 : code;
        return (eff == 0) ? 0 : (1 << (eff - 1));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference model, updated on each rising edge.
    int m_div = 0, m_cnt = 0, m_per = 0;
    bit m_tick = 0, m_pf = 0, m_sqw = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div <= 0; m_tick <= 0; m_cnt <= 0; m_pf <= 0; m_sqw <= 0;
        end else begin
            int  per;
            bit  ev;
            per = period_of(rate_sel);
            ev  = m_tick && per != 0 && (pie_en || sqw_en) && (((m_cnt + 1) % per) == 0);
            m_div  <= (m_div == DIV - 1) ? 0 : m_div + 1;  // R9 tick spacing
            m_tick <= (m_div == DIV - 1);
            if (m_tick) m_cnt <= (m_cnt + 1) % 32768;
            m_per <= per;
            m_pf  <= ev && pie_en;
            if (!sqw_en) m_sqw <= 0;
            else if (ev) m_sqw <= !m_sqw;
        end
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(pf_set == m_pf, "R6 pf_set", pf_set, m_pf);
            check(irq_set == m_pf, "R6 irq_set", irq_set, m_pf);
            check(sqw_out == m_sqw, "R7 sqw_out", sqw_out, m_sqw);
            if (pf_set && m_per != 0)
                check((m_cnt % m_per) == 0, "R5 alignment", m_cnt % m_per, 0);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic measure_gap(input int exp, input string req);
        int n;
        @(negedge clk);
        while (!pf_set) @(negedge clk);
        n = 0;
        do begin @(negedge clk); n++; end while (!pf_set);
        check(n == exp, req, n, exp);
    endtask

    task automatic count_run(input int ncyc, output int pulses, output int toggles);
        bit last;
        pulses = 0; toggles = 0; last = sqw_out;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (pf_set) pulses++;
            if (sqw_out != last) toggles++;
            last = sqw_out;
        end
    endtask

    initial begin
        int p, t;
        repeat (3) @(negedge clk);
        check(pf_set == 0 && irq_set == 0 && sqw_out == 0, "R10 reset", {pf_set, irq_set, sqw_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pf_set == 0 && sqw_out == 0, "R10 after reset", {pf_set, sqw_out}, 0);

        rate_sel = 4'd3; pie_en = 1'b1;
        measure_gap(4 * DIV, "R3 code 3");
        measure_gap(4 * DIV, "R9 tick spacing");
        rate_sel = 4'd6;
        measure_gap(32 * DIV, "R3 code 6");
        rate_sel = 4'd1;
        measure_gap(128 * DIV, "R2 code 1");
        rate_sel = 4'd2;
        measure_gap(256 * DIV, "R2 code 2");

        // R8: change in mid period, from code 6 to code 4.
        rate_sel = 4'd6;
        measure_gap(32 * DIV, "R8 before change");
        repeat (40) @(negedge clk);
        rate_sel = 4'd4;
        count_run(400, p, t);
        check(p >= 11 && p <= 13, "R8 pulses at new rate", p, 12);

        rate_sel = 4'd0;
        count_run(600, p, t);
        check(p == 0, "R1 code 0 pulses", p, 0);

        rate_sel = 4'd3; pie_en = 1'b0; sqw_en = 1'b0;
        count_run(200, p, t);
        check(p == 0 && sqw_out == 0, "R4 both disabled", p, 0);

        sqw_en = 1'b1;
        count_run(320, p, t);
        check(p == 0, "R7 no pf without pie", p, 0);
        check(t >= 19 && t <= 21, "R7 sqw toggles", t, 20);
        sqw_en = 1'b0;
        @(negedge clk);
        check(sqw_out == 0, "R7 sqw low when off", sqw_out, 0);

        rate_sel = 4'd15; pie_en = 1'b1; sqw_en = 1'b1;
        count_run(2000, p, t);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule